// File: doc/BRIEF.md
# Segment Limit Load and Check Unit

This unit performs a load-segment-limit operation for a processor pipeline. A start strobe hands it a segment selector, the 64-bit descriptor already fetched from the descriptor table, that table's limit, the current privilege level, a long-mode flag and an operand-size code. The unit decides whether the descriptor may be inspected by checking three things: the table bounds, the descriptor type and the privilege rules. It rebuilds the 20-bit limit from its two split fields and expands it when the limit counts in 4 KiB units. It then sizes the result for the destination register.

One cycle after the strobe, the unit presents the new destination value, a write-enable and a zero flag, together with a done pulse. The zero flag is set on success. On failure the write-enable stays low and the destination value does not change. No fault is raised in either case. Fetching the descriptor, faults on the memory operand and paging are all handled elsewhere.

Top module: `seglim_unit`

## Requirements
- R1: Only bits 15:0 of the 32-bit selector source are used. Bits 31:16 have no effect on any output.
- R2: The raw 20-bit limit is assembled from descriptor bits 15:0 (limit 15:0) and descriptor bits 51:48 (limit 19:16).
- R3: When descriptor bit 55 (granularity) is 1, the byte limit is the raw limit shifted left by 12 with bits 11:0 set to ones. When bit 55 is 0, the byte limit is the raw limit itself.
- R4: Operand-size code 2'b00 (16-bit) replaces only destination bits 15:0 with the low 16 bits of the byte limit and keeps bits 63:16. Code 2'b01 (32-bit) and codes 2'b1x (64-bit) write the 32-bit byte limit zero-extended to 64 bits.
- R5: The operation fails when the last byte of the selected entry, {selector[15:3], 3'b111}, is greater than the table limit.
- R6: The descriptor's DPL is in bits 46:45. A conforming code segment has S (bit 44) = 1 and type bits 43 and 42 both 1. For any descriptor that is not a conforming code segment, the operation fails when CPL > DPL or when RPL (selector bits 1:0) > DPL. Conforming code segments skip this check.
- R7: Outside long mode, a system descriptor (S = 0, type in bits 43:40) passes the type check only for types 1, 2, 3, 9 and 11. Code and data descriptors (S = 1) always pass it.
- R8: In long mode, a system descriptor passes the type check only for types 2, 9 and 11.
- R9: At completion, the zero flag is 1 and the write-enable is 1 exactly when all checks pass. On failure the destination value stays the same.
- R10: The done pulse is high for exactly the cycle after a start strobe, and the write-enable is never high outside it. The zero flag and the destination value hold between operations.
- R11: After synchronous reset, done, write-enable, the zero flag and the destination value are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe; samples all operands |
| sel_src_i | input | 32 | Selector source; only bits 15:0 used |
| desc_i | input | 64 | Descriptor read from the table |
| tbl_limit_i | input | 16 | Descriptor table limit in bytes |
| cpl_i | input | 2 | Current privilege level |
| long_mode_i | input | 1 | 1 selects the long-mode type rules |
| opsize_i | input | 2 | 00 = 16-bit, 01 = 32-bit, 1x = 64-bit |
| done_o | output | 1 | One-cycle completion pulse |
| zf_o | output | 1 | Zero flag: 1 on success |
| wr_en_o | output | 1 | Destination register write-enable |
| dest_o | output | 64 | Destination register value |

## Verification
The bench targets the edges of the checks. It places the entry end exactly at the table limit and one byte past it, which exposes an off-by-one in the bounds compare. It sets RPL and CPL just above and just at DPL, and it tries a conforming code segment at a privilege that would otherwise be denied; a design that mishandles the exemption either rejects that segment or lets a non-conforming one through. It sweeps all sixteen system types in both modes, so a wrong acceptance mask shows up as a flipped zero flag. It also runs a 16-bit load after a wide one, so a design that clears the upper destination bits, or forgets the ones-fill under page granularity, returns a wrong value. Randomised operands round out the checks against the behavioural model every clock.

// File: rtl/seglim_pkg.sv
package seglim_pkg;

  typedef enum logic [1:0] {
    OSZ_16  = 2'b00,
    OSZ_32  = 2'b01,
    OSZ_64  = 2'b10,
    OSZ_64B = 2'b11
  } opsize_e;

  typedef struct packed {
    logic [19:0] raw_lim;
    logic        gran;
    logic [1:0]  dpl;
    logic        s_bit;
    logic [3:0]  dtype;
  } desc_fields_t;

  function automatic desc_fields_t unpack_desc(input logic [63:0] d);
    desc_fields_t f;
    f.raw_lim = {d[51:48], d[15:0]};
    f.gran    = d[55];
    f.dpl     = d[46:45];
    f.s_bit   = d[44];
    f.dtype   = d[43:40];
    return f;
  endfunction

endpackage

// File: rtl/seglim_check.sv
module seglim_check #(
  parameter int TBL_W       = 16,
  parameter int IDX_LSB     = 3,
  parameter logic [15:0] LEGACY_SYS_OK = 16'h0A0E,
  parameter logic [15:0] LONG_SYS_OK   = 16'h0A04
) (
  input  logic [TBL_W-1:0] sel,
  input  logic [TBL_W-1:0] tbl_limit,
  input  logic [1:0]       cpl,
  input  logic             long_mode,
  input  seglim_pkg::desc_fields_t fld,
  output logic             ok
);
  logic [TBL_W:0] entry_end;
  logic           bound_ok;
  logic [15:0]    sys_mask;
  logic           type_ok;
  logic           conforming;
  logic [1:0]     rpl;
  logic           priv_ok;

  always_comb begin
    entry_end  = {1'b0, sel[TBL_W-1:IDX_LSB], {IDX_LSB{1'b1}}};
    bound_ok   = !(entry_end > {1'b0, tbl_limit});
    sys_mask   = long_mode ? LONG_SYS_OK : LEGACY_SYS_OK;
    type_ok    = fld.s_bit | sys_mask[fld.dtype];
    conforming = fld.s_bit & fld.dtype[3] & fld.dtype[2];
    rpl        = sel[1:0];
    priv_ok    = conforming | ((cpl <= fld.dpl) & (rpl <= fld.dpl));
    ok         = bound_ok & type_ok & priv_ok;
  end
endmodule

// File: rtl/seglim_extract.sv
module seglim_extract #(
  parameter int LIM_W      = 20,
  parameter int GRAN_SHIFT = 12,
  parameter int NARROW_W   = 16,
  parameter int DEST_W     = 64
) (
  input  logic [LIM_W-1:0]  raw_lim,
  input  logic              gran,
  input  logic [1:0]        opsize,
  input  logic [DEST_W-1:0] prev_dest,
  output logic [DEST_W-1:0] next_dest
);
  localparam int BYTE_W = LIM_W + GRAN_SHIFT;

  logic [BYTE_W-1:0] byte_lim;
  logic [DEST_W-1:0] wide;

  always_comb begin
    if (gran) byte_lim = {raw_lim, {GRAN_SHIFT{1'b1}}};
    else      byte_lim = {{GRAN_SHIFT{1'b0}}, raw_lim};
    wide = '0;
    wide[BYTE_W-1:0] = byte_lim;
    if (opsize == seglim_pkg::OSZ_16)
      next_dest = {prev_dest[DEST_W-1:NARROW_W], byte_lim[NARROW_W-1:0]};
    else
      next_dest = wide;
  end
endmodule

// File: rtl/seglim_unit.sv
module seglim_unit #(
  parameter int SRC_W  = 32,
  parameter int SEL_W  = 16,
  parameter int DESC_W = 64,
  parameter int DEST_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [SRC_W-1:0]  sel_src_i,
  input  logic [DESC_W-1:0] desc_i,
  input  logic [SEL_W-1:0]  tbl_limit_i,
  input  logic [1:0]        cpl_i,
  input  logic              long_mode_i,
  input  logic [1:0]        opsize_i,
  output logic              done_o,
  output logic              zf_o,
  output logic              wr_en_o,
  output logic [DEST_W-1:0] dest_o
);
  import seglim_pkg::*;

  desc_fields_t      fld;
  logic [SEL_W-1:0]  sel;
  logic              pass;
  logic [DEST_W-1:0] sized;

  assign sel = sel_src_i[SEL_W-1:0];
  assign fld = unpack_desc(desc_i);

  seglim_check #(.TBL_W(SEL_W)) u_check (
    .sel       (sel),
    .tbl_limit (tbl_limit_i),
    .cpl       (cpl_i),
    .long_mode (long_mode_i),
    .fld       (fld),
    .ok        (pass)
  );

  seglim_extract #(.DEST_W(DEST_W)) u_extract (
    .raw_lim   (fld.raw_lim),
    .gran      (fld.gran),
    .opsize    (opsize_i),
    .prev_dest (dest_o),
    .next_dest (sized)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o  <= 1'b0;
      zf_o    <= 1'b0;
      wr_en_o <= 1'b0;
      dest_o  <= '0;
    end else begin
      done_o  <= start_i;
      wr_en_o <= start_i & pass;
      if (start_i) begin
        zf_o <= pass;
        if (pass) dest_o <= sized;
      end
    end
  end
endmodule

// File: rtl/seglim_sva.sv
module seglim_sva (
  input logic        clk,
  input logic        rst,
  input logic        start_i,
  input logic [31:0] sel_src_i,
  input logic [63:0] desc_i,
  input logic [15:0] tbl_limit_i,
  input logic [1:0]  opsize_i,
  input logic        done_o,
  input logic        zf_o,
  input logic        wr_en_o,
  input logic [63:0] dest_o
);
  // R10
  done_follows_start_chk: assert property (@(posedge clk) disable iff (rst)
    done_o == $past(start_i));

  // R9
  wr_needs_zf_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> (zf_o && done_o));

  // R9
  dest_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en_o |-> $stable(dest_o));

  // R10
  zf_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(zf_o));

  // R3
  gran_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en_o && $past(desc_i[55])) |-> (dest_o[11:0] == 12'hFFF));

  // R4
  wide_zero_ext_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en_o && $past(opsize_i) != 2'b00) |-> (dest_o[63:32] == 32'h0));

  // R5
  bound_fail_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(start_i) && ({1'b0, $past(sel_src_i[15:3]), 3'b111} > {1'b0, $past(tbl_limit_i)}))
      |-> (!zf_o && !wr_en_o));
endmodule

bind seglim_unit seglim_sva u_seglim_sva (
  .clk         (clk),
  .rst         (rst),
  .start_i     (start_i),
  .sel_src_i   (sel_src_i),
  .desc_i      (desc_i),
  .tbl_limit_i (tbl_limit_i),
  .opsize_i    (opsize_i),
  .done_o      (done_o),
  .zf_o        (zf_o),
  .wr_en_o     (wr_en_o),
  .dest_o      (dest_o)
);

// File: tb/seglim_unit_bench.sv
module seglim_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [31:0] sel_src_i = '0;
  logic [63:0] desc_i = '0;
  logic [15:0] tbl_limit_i = '0;
  logic [1:0]  cpl_i = '0;
  logic        long_mode_i = 1'b0;
  logic [1:0]  opsize_i = '0;
  logic        done_o, zf_o, wr_en_o;
  logic [63:0] dest_o;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  // reference state
  logic        m_done = 0, m_zf = 0, m_wr = 0;
  logic [63:0] m_dest = '0;

  always #2 clk = ~clk;

  seglim_unit u_seglim_unit (
    .clk(clk), .rst(rst), .start_i(start_i), .sel_src_i(sel_src_i),
    .desc_i(desc_i), .tbl_limit_i(tbl_limit_i), .cpl_i(cpl_i),
    .long_mode_i(long_mode_i), .opsize_i(opsize_i), .done_o(done_o),
    .zf_o(zf_o), .wr_en_o(wr_en_o), .dest_o(dest_o)
  );

  function automatic bit ref_ok(input int sel, input longint d, input int lim,
                                input int cpl, input bit lm);
    int dpl, typ, rpl, last;
    bit s, conf, tok;
    dpl = int'((d >> 45) & 3);
    typ = int'((d >> 40) & 15);
    s   = d[44];
    rpl = sel & 3;
    last = (sel & 'hFFF8) + 7;
    if (last > lim) return 0;
    if (s) tok = 1;
    else if (lm) tok = (typ == 2 || typ == 9 || typ == 11);
    else tok = (typ == 1 || typ == 2 || typ == 3 || typ == 9 || typ == 11);
    if (!tok) return 0;
    conf = s && (typ >= 12);
    if (!conf && (cpl > dpl || rpl > dpl)) return 0;
    return 1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_done <= 0; m_zf <= 0; m_wr <= 0; m_dest <= '0;
    end else begin
      m_done <= start_i;
      m_wr   <= 0;
      if (start_i) begin
        longint rawl, bl;
        bit ok;
        ok = ref_ok(int'(sel_src_i[15:0]), longint'(desc_i), int'(tbl_limit_i),
                    int'(cpl_i), long_mode_i);
        rawl = (longint'(desc_i[51:48]) * 65536) + longint'(desc_i[15:0]);
        bl = desc_i[55] ? (rawl * 4096 + 4095) : rawl;
        m_zf <= ok;
        m_wr <= ok;
        if (ok) begin
          if (opsize_i == 2'b00)
            m_dest <= (m_dest & 64'hFFFF_FFFF_FFFF_0000) | (bl & 64'hFFFF);
          else
            m_dest <= bl & 64'hFFFF_FFFF;
        end
      end
    end
  end

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk(tag, "done", longint'(done_o), longint'(m_done));
    chk(tag, "zf", longint'(zf_o), longint'(m_zf));
    chk(tag, "wr_en", longint'(wr_en_o), longint'(m_wr));
    chk(tag, "dest", longint'(dest_o), longint'(m_dest));
  endtask

  // per-clock comparison against the model (R10 hold behaviour)
  always @(negedge clk) if (!rst) chk_all("R10");

  function automatic logic [63:0] mk_desc(input logic [19:0] lim, input bit g,
                                          input bit s, input logic [3:0] typ,
                                          input logic [1:0] dpl);
    logic [63:0] d;
    d = '0;
    d[15:0] = lim[15:0];
    d[51:48] = lim[19:16];
    d[55] = g; d[47] = 1'b1; d[46:45] = dpl; d[44] = s; d[43:40] = typ;
    return d;
  endfunction

  task automatic run_op(input string tag, input logic [31:0] sel, input logic [63:0] d,
                        input logic [15:0] lim, input logic [1:0] cpl,
                        input bit lm, input logic [1:0] osz,
                        input bit exp_zf);
    @(negedge clk);
    sel_src_i = sel; desc_i = d; tbl_limit_i = lim; cpl_i = cpl;
    long_mode_i = lm; opsize_i = osz; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk_all(tag);
    chk(tag, "zf vs plan", longint'(zf_o), longint'(exp_zf));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected<=100000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    chk("R11", "done", longint'(done_o), 0);
    chk("R11", "zf", longint'(zf_o), 0);
    chk("R11", "wr_en", longint'(wr_en_o), 0);
    chk("R11", "dest", longint'(dest_o), 0);

    // R2 byte-granular 32-bit load
    run_op("R2", 32'h0008, mk_desc(20'hABCDE, 0, 1, 4'h2, 2'd3), 16'h00FF, 2'd0, 0, 2'b01, 1);
    chk("R2", "value", longint'(dest_o), 64'h000A_BCDE);
    // R3 page granular, 64-bit size
    run_op("R3", 32'h0010, mk_desc(20'h12345, 1, 1, 4'h2, 2'd0), 16'h00FF, 2'd0, 0, 2'b10, 1);
    chk("R3", "value", longint'(dest_o), 64'h1234_5FFF);
    // R4 16-bit keeps upper bits
    run_op("R4", 32'h0010, mk_desc(20'h0BEEF, 0, 1, 4'h2, 2'd0), 16'h00FF, 2'd0, 0, 2'b00, 1);
    chk("R4", "value", longint'(dest_o), 64'h1234_BEEF);
    run_op("R4", 32'h0010, mk_desc(20'hFFFFF, 1, 1, 4'h2, 2'd0), 16'h00FF, 2'd0, 0, 2'b11, 1);
    chk("R4", "value", longint'(dest_o), 64'hFFFF_FFFF);
    // R1 upper source bits ignored
    run_op("R1", 32'hFFFF_0008, mk_desc(20'h00042, 0, 1, 4'h2, 2'd3), 16'h000F, 2'd0, 0, 2'b01, 1);
    chk("R1", "value", longint'(dest_o), 64'h42);
    // R5 bound edge
    run_op("R5", 32'h0010, mk_desc(20'h00077, 0, 1, 4'h2, 2'd0), 16'h0016, 2'd0, 0, 2'b01, 0);
    chk("R9", "dest unchanged", longint'(dest_o), 64'h42);
    run_op("R5", 32'h0010, mk_desc(20'h00077, 0, 1, 4'h2, 2'd0), 16'h0017, 2'd0, 0, 2'b01, 1);
    // R6 privilege
    run_op("R6", 32'h0008, mk_desc(20'h1, 0, 1, 4'h2, 2'd1), 16'hFFFF, 2'd2, 0, 2'b01, 0);
    run_op("R6", 32'h000B, mk_desc(20'h1, 0, 1, 4'h2, 2'd2), 16'hFFFF, 2'd0, 0, 2'b01, 0);
    run_op("R6", 32'h000A, mk_desc(20'h2, 0, 1, 4'hA, 2'd2), 16'hFFFF, 2'd2, 0, 2'b01, 1);
    run_op("R6", 32'h000B, mk_desc(20'h3, 0, 1, 4'hE, 2'd0), 16'hFFFF, 2'd3, 0, 2'b01, 1);
    // R7 legacy system types
    for (int t = 0; t < 16; t++)
      run_op("R7", 32'h0008, mk_desc(20'h55, 0, 0, 4'(t), 2'd0), 16'hFFFF, 2'd0, 0, 2'b01,
             (t == 1 || t == 2 || t == 3 || t == 9 || t == 11));
    // R8 long mode system types
    for (int t = 0; t < 16; t++)
      run_op("R8", 32'h0008, mk_desc(20'h66, 1, 0, 4'(t), 2'd0), 16'hFFFF, 2'd0, 1, 2'b10,
             (t == 2 || t == 9 || t == 11));
    // R9 randomised operands
    for (int i = 0; i < 300; i++) begin
      logic [31:0] rs;
      logic [63:0] rd;
      bit e;
      rs = $urandom;
      rd = {$urandom, $urandom};
      e = ref_ok(int'(rs[15:0]), longint'(rd), 'h8000, int'(i % 4), bit'(i % 3 == 0));
      run_op("R9", rs, rd, 16'h8000, 2'(i % 4), bit'(i % 3 == 0), 2'(i % 4), e);
    end
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule